// File: doc/BRIEF.md
# Bidirectional Cascadable Gate Scan Shifter

This block is the digital core of a display row-scan driver. A start pulse enters at one end of a 128-stage shift register and advances one stage on every rising edge of the shift clock, so that exactly one scan output is active at a time. A direction input picks which end of the register is the entry, and a length input picks whether 120 or all 128 stages take part in the scan. In the short setting, the stages above 120 are bypassed and stay low.

Two start-pulse pins, one at each end, can each be driven or released. The pin at the entry end for the current direction is released and read as the start input. The pin at the far end drives the cascade pulse that starts the next driver in a chain. The cascade pulse is timed on falling clock edges, half a clock after the shift. A blanking input, which is asynchronous to the shift clock, forces every scan output low through gating logic only. The register keeps its contents and keeps shifting while blanking is active.

The start pins are level signals sampled by the shift clock, with no handshake. A stream-style valid/ready interface would not fit a pulse that must advance on every clock, so the block has no back-pressure.

Top module: `gate_scan_shifter`

## Requirements
- R1: On each rising edge of `clk` the register takes the entry pin into its first stage and moves every other active stage by one position. Nothing changes between rising edges.
- R2: With `scan_dir` = 1, a pulse on `sp_r_i` appears on `scan_o[0]` after the 1st rising edge and on `scan_o[k-1]` after the k-th. The cascade pulse leaves on `sp_l_o`, and `sp_l_i` is ignored.
- R3: With `scan_dir` = 0, a pulse on `sp_l_i` appears on `scan_o[L-1]` after the 1st rising edge and on `scan_o[L-k]` after the k-th, where L is the active length. The cascade pulse leaves on `sp_r_o`, and `sp_r_i` is ignored.
- R4: With `short_mode` = 1 the active length L is 120, and `scan_o[127:120]` stay low in both directions. With `short_mode` = 0, L is 128.
- R5: The cascade output goes high on the falling edge of the L-th clock after the start pulse was captured. It goes low on the falling edge of the (L+1)-th clock.
- R6: While `blank` = 1, every bit of `scan_o` is 0, and this takes effect without a clock edge. The register keeps its contents and keeps shifting, so when `blank` returns to 0 the pulse shows at the position it would have reached anyway.
- R7: A high `rst` clears all stages on a rising edge and clears the cascade output on a falling edge.
- R8: `sp_l_oe` = `scan_dir` and `sp_r_oe` = not `scan_dir`, so exactly one start pin is driven at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; shift on rise, cascade on fall |
| rst | input | 1 | Synchronous active-high reset |
| scan_dir | input | 1 | 1: scan from output 1 upward; 0: downward |
| short_mode | input | 1 | 1: 120 active stages; 0: 128 |
| blank | input | 1 | Asynchronous force-low of all scan outputs |
| sp_r_i | input | 1 | Right start pin, input side |
| sp_r_o | output | 1 | Right start pin, cascade drive |
| sp_r_oe | output | 1 | Right start pin drive enable |
| sp_l_i | input | 1 | Left start pin, input side |
| sp_l_o | output | 1 | Left start pin, cascade drive |
| sp_l_oe | output | 1 | Left start pin drive enable |
| scan_o | output | 128 | Gated scan outputs, bit 0 is output 1 |

## Verification
The bench sweeps all four combinations of direction and length, following a single pulse across every stage and past the end. It checks the whole output vector each cycle, so a design that wrapped the pulse, left the bypassed tail active in the short setting, or took the entry from the wrong stage in downward scans would show a stray or missing bit. It holds the far-end pin high throughout, which catches a design that reads the wrong pin. It samples the cascade pin just after each falling edge, so a cascade off by one clock, or by half a clock (registered on the rising edge), is reported. Blanking is raised both between edges and across edges. This exposes a registered mask, and also a design that froze or cleared the register while blanking was active.

// File: rtl/gss_pkg.sv
package gss_pkg;
  localparam int GSS_STAGES = 128;
  localparam int GSS_SHORT  = 120;

  typedef enum logic {
    SCAN_DOWN = 1'b0,
    SCAN_UP   = 1'b1
  } scan_dir_e;
endpackage

// File: rtl/gss_stage_chain.sv
module gss_stage_chain #(
  parameter int N  = 128,
  parameter int NS = 120
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         dir_up,
  input  logic         short_mode,
  input  logic         sp_r_i,
  input  logic         sp_l_i,
  output logic [N-1:0] stages
);
  logic [N-1:0] from_lo;
  logic [N-1:0] from_hi;
  logic [N-1:0] nxt;

  always_comb begin
    from_lo = {stages[N-2:0], sp_r_i};
    from_hi = {1'b0, stages[N-1:1]};
    if (short_mode) from_hi[NS-1] = sp_l_i;
    else            from_hi[N-1]  = sp_l_i;
  end

  for (genvar i = 0; i < N; i++) begin : g_stage
    localparam bit IN_SHORT = (i < NS);
    if (IN_SHORT) begin : g_core
      assign nxt[i] = dir_up ? from_lo[i] : from_hi[i];
    end else begin : g_tail
      assign nxt[i] = !short_mode && (dir_up ? from_lo[i] : from_hi[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stages <= '0;
    else     stages <= nxt;
  end

  // R1: upward step from stage 0 to stage 1
  a_r1_up_step: assert property (@(posedge clk) disable iff (rst)
    dir_up |=> stages[1] == $past(stages[0]));
  // R1: downward step from stage 1 to stage 0
  a_r1_down_step: assert property (@(posedge clk) disable iff (rst)
    !dir_up |=> stages[0] == $past(stages[1]));
  // R4: bypassed tail stays idle in the short setting
  a_r4_tail_idle: assert property (@(posedge clk) disable iff (rst)
    short_mode |=> stages[N-1:NS] == '0);
  // R7: reset empties the register
  a_r7_reset_clear: assert property (@(posedge clk)
    rst |=> stages == '0);
endmodule

// File: rtl/gss_cascade.sv
module gss_cascade #(
  parameter int N  = 128,
  parameter int NS = 120
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         dir_up,
  input  logic         short_mode,
  input  logic [N-1:0] stages,
  output logic         sp_r_o,
  output logic         sp_r_oe,
  output logic         sp_l_o,
  output logic         sp_l_oe
);
  logic tail_tap;
  logic casc_q;

  always_comb begin
    if (!dir_up)        tail_tap = stages[0];
    else if (short_mode) tail_tap = stages[NS-1];
    else                 tail_tap = stages[N-1];
  end

  always_ff @(negedge clk) begin
    if (rst) casc_q <= 1'b0;
    else     casc_q <= tail_tap;
  end

  assign sp_l_o  = casc_q;
  assign sp_r_o  = casc_q;
  assign sp_l_oe = dir_up;
  assign sp_r_oe = !dir_up;

  // R5: the far-end stage raises the cascade on the next falling edge
  a_r5_casc_rise: assert property (@(negedge clk) disable iff (rst)
    tail_tap |=> casc_q);
  // R5: the cascade drops once the far-end stage is empty
  a_r5_casc_fall: assert property (@(negedge clk) disable iff (rst)
    !tail_tap |=> !casc_q);
  // R8: exactly one start pin is driven
  a_r8_one_driver: assert property (@(posedge clk) disable iff (rst)
    $countones({sp_l_oe, sp_r_oe}) == 1);
endmodule

// File: rtl/gss_out_gate.sv
module gss_out_gate #(
  parameter int N = 128
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         blank,
  input  logic [N-1:0] stages,
  output logic [N-1:0] scan_o
);
  assign scan_o = stages & {N{!blank}};

  // R6: blanking holds every scan line low
  a_r6_blank_low: assert property (@(posedge clk) disable iff (rst)
    blank |-> scan_o == '0);
endmodule

// File: rtl/gate_scan_shifter.sv
module gate_scan_shifter
  import gss_pkg::*;
#(
  parameter int N_STAGES = GSS_STAGES,
  parameter int N_SHORT  = GSS_SHORT
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                scan_dir,
  input  logic                short_mode,
  input  logic                blank,
  input  logic                sp_r_i,
  output logic                sp_r_o,
  output logic                sp_r_oe,
  input  logic                sp_l_i,
  output logic                sp_l_o,
  output logic                sp_l_oe,
  output logic [N_STAGES-1:0] scan_o
);
  scan_dir_e            dir_sel;
  logic                 dir_up;
  logic [N_STAGES-1:0]  stages;

  assign dir_sel = scan_dir_e'(scan_dir);
  assign dir_up  = (dir_sel == SCAN_UP);

  gss_stage_chain #(.N(N_STAGES), .NS(N_SHORT)) u_chain (
    .clk(clk), .rst(rst), .dir_up(dir_up), .short_mode(short_mode),
    .sp_r_i(sp_r_i), .sp_l_i(sp_l_i), .stages(stages)
  );

  gss_cascade #(.N(N_STAGES), .NS(N_SHORT)) u_casc (
    .clk(clk), .rst(rst), .dir_up(dir_up), .short_mode(short_mode),
    .stages(stages), .sp_r_o(sp_r_o), .sp_r_oe(sp_r_oe),
    .sp_l_o(sp_l_o), .sp_l_oe(sp_l_oe)
  );

  gss_out_gate #(.N(N_STAGES)) u_gate (
    .clk(clk), .rst(rst), .blank(blank), .stages(stages), .scan_o(scan_o)
  );
endmodule

// File: tb/tb_gate_scan_shifter.sv
module tb_gate_scan_shifter;
  localparam int N  = 128;
  localparam int NS = 120;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scan_dir = 1'b1, short_mode = 1'b0, blank = 1'b0;
  logic sp_r_i = 1'b0, sp_l_i = 1'b0;
  logic sp_r_o, sp_r_oe, sp_l_o, sp_l_oe;
  logic [N-1:0] scan_o;

  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  gate_scan_shifter dut (
    .clk(clk), .rst(rst), .scan_dir(scan_dir), .short_mode(short_mode),
    .blank(blank), .sp_r_i(sp_r_i), .sp_r_o(sp_r_o), .sp_r_oe(sp_r_oe),
    .sp_l_i(sp_l_i), .sp_l_o(sp_l_o), .sp_l_oe(sp_l_oe), .scan_o(scan_o)
  );

  task automatic check_vec(input string tag, input logic [N-1:0] act,
                           input logic [N-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_bit(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] expect_scan(input logic up, input int len,
                                               input int k, input logic blk);
    logic [N-1:0] v = '0;
    if (!blk && k >= 1 && k <= len) begin
      if (up) v[k-1] = 1'b1;
      else    v[len-k] = 1'b1;
    end
    return v;
  endfunction

  task automatic do_reset();
    @(negedge clk); #1 rst = 1'b1;
    @(posedge clk);
    @(negedge clk); #1 rst = 1'b0;
  endtask

  task automatic sweep(input logic up, input logic shrt);
    int len = shrt ? NS : N;
    scan_dir = up; short_mode = shrt; blank = 1'b0;
    sp_r_i = 1'b0; sp_l_i = 1'b0;
    do_reset();
    // entry pin pulses once; far pin held high and must be ignored (R2/R3)
    if (up) begin sp_r_i = 1'b1; sp_l_i = 1'b1; end
    else    begin sp_l_i = 1'b1; sp_r_i = 1'b1; end
    for (int k = 1; k <= len + 2; k++) begin
      @(posedge clk); #3;
      check_vec(up ? "R2/R4 upward position" : "R3/R4 downward position",
                scan_o, expect_scan(up, len, k, blank));
      if (blank) check_vec("R6 blank across edge", scan_o, '0);
      @(negedge clk); #1;
      check_bit("R5 cascade pulse", up ? sp_l_o : sp_r_o, k == len);
      if (k == 5) begin
        check_bit("R8 left pin drive", sp_l_oe, up);
        check_bit("R8 right pin drive", sp_r_oe, !up);
      end
      if (k == 20) begin
        blank = 1'b1; #2;
        check_vec("R6 async blank", scan_o, '0);
        blank = 1'b0; #2;
        check_vec("R6 unblank restores", scan_o, expect_scan(up, len, k, 1'b0));
      end
      if (up) sp_r_i = 1'b0; else sp_l_i = 1'b0;
      blank = (k >= 9 && k <= 12);
    end
  endtask

  initial begin : watchdog
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
    $finish;
  end

  initial begin
    @(posedge clk);
    @(negedge clk); #1;
    check_vec("R7 reset scan", scan_o, '0);
    check_bit("R7 reset cascade", sp_l_o, 1'b0);
    sweep(1'b1, 1'b0);
    sweep(1'b1, 1'b1);
    sweep(1'b0, 1'b0);
    sweep(1'b0, 1'b1);
    // R7: reset with cascade high clears it and the register
    scan_dir = 1'b1; short_mode = 1'b1; sp_l_i = 1'b0;
    do_reset();
    sp_r_i = 1'b1;
    for (int k = 1; k <= NS; k++) begin
      @(posedge clk);
      @(negedge clk); #1 sp_r_i = 1'b0;
    end
    check_bit("R5 cascade before reset", sp_l_o, 1'b1);
    sp_r_i = 1'b1; rst = 1'b1;
    @(posedge clk); #3;
    check_vec("R7 mid-scan reset scan", scan_o, '0);
    @(negedge clk); #1;
    check_bit("R7 mid-scan reset cascade", sp_l_o, 1'b0);
    rst = 1'b0; sp_r_i = 1'b0;
    // R1: nothing moves between rising edges
    @(posedge clk); #3;
    check_vec("R1 between edges", scan_o, '0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule